// File: doc/BRIEF.md
# Lookup-Table Scratch Memory Cell

This block models the memory use of a logic cell's two 4-input lookup tables. Each table holds 16 one-bit entries that can be rewritten at run time. A two-bit arrangement input picks how the tables are combined:

- two independent 16x1 memories;
- one 32x1 memory, where a data pin becomes the top address bit;
- one 16x1 memory with a write/read port and a second read-only port.

Writes are synchronous to the rising clock edge, and the write enable acts as a plain clock enable. Reads are combinational from the current addresses.

The block is used where a few bits of scratch storage must sit right next to logic: small register files, shift-free delay lines and lookup tables that software or a state machine rewrites. The storage cells have no reset, so their contents are undefined at power-up until they are written. The asynchronous active-low reset only blocks writes. Its release passes through a two-stage synchronizer.

Top module: `cellram_top`

## Requirements
- R1: With arrangement 2'b00 (split), the edge write stores `wd_a` at `adr_a` in table A and `wd_b` at `adr_b` in table B. Both writes are independent, even when the two addresses are equal. `rd_a` shows A[`adr_a`] and `rd_b` shows B[`adr_b`].
- R2: With arrangement 2'b01 (wide), `wd_b` acts as address bit 4. A write stores `wd_a` at A[`adr_a`] when `wd_b`=0, or at B[`adr_a`] when `wd_b`=1. The other table is left unchanged.
- R3: In wide arrangement, `rd_wide` shows location {`wd_b`,`adr_a`} of the 32-entry memory. `rd_a` shows A[`adr_a`] and `rd_b` shows B[`adr_a`].
- R4: With arrangement 2'b10 (dual-port), a write stores `wd_a` at `adr_a` in both tables, and `wd_b` is ignored. `rd_a` reads location `adr_a` and `rd_b` reads location `adr_b` of the shared content.
- R5: A location changes only at a rising `clk` edge at which `wen` is high. With `wen` low, no location changes, whatever the other inputs do.
- R6: Reads are combinational. A write to the address being read shows the old value before the edge and the new value right after it, on every read port that addresses it.
- R7: Arrangement 2'b11 is reserved. It performs no write, and it reads as the split arrangement.
- R8: No write happens while `rst_n` is low, nor at the first two rising edges after `rst_n` goes high. The third edge can write. Stored contents survive reset.
- R9: In arrangements other than wide, `rd_wide` equals `rd_a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, write block only |
| arrange | input | 2 | Arrangement: 00 split, 01 wide, 10 dual-port, 11 reserved |
| adr_a | input | 4 | Table A address; write address in wide and dual-port |
| adr_b | input | 4 | Table B address; second read address in dual-port |
| wd_a | input | 1 | Write data for table A, or the only write data |
| wd_b | input | 1 | Write data for table B, or address bit 4 in wide |
| wen | input | 1 | Write enable, sampled at the rising edge |
| rd_a | output | 1 | Combinational read of table A |
| rd_b | output | 1 | Combinational read of table B |
| rd_wide | output | 1 | Read of the selected half in wide arrangement |

## Verification
The hardest situation to reach is the write-suppression window right after reset release. Reaching it needs known contents, so the stimulus first fills every location. It then holds reset low while writing, and releases reset on a falling edge. Writes are then attempted at exactly the first three rising edges, with no idle cycles in between. Only then are the addresses read back, because every read spends a clock edge that would otherwise close the window. Read-during-write is sampled both before and after the same edge on both ports.

// File: rtl/cellram_pkg.sv
package cellram_pkg;
  typedef enum logic [1:0] {
    ARR_SPLIT = 2'b00,
    ARR_WIDE  = 2'b01,
    ARR_DPORT = 2'b10,
    ARR_RSVD  = 2'b11
  } arrange_e;

  localparam int TABLES = 2;
endpackage

// File: rtl/cellram_rst_sync.sv
module cellram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign ready = sync_q[STAGES-1];
endmodule

// File: rtl/cellram_wr_dec.sv
module cellram_wr_dec
  import cellram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic                        rst_n,
  input  logic                        clk,
  input  arrange_e                    arr,
  input  logic [AW-1:0]               adr_a,
  input  logic [AW-1:0]               adr_b,
  input  logic                        wd_a,
  input  logic                        wd_b,
  input  logic                        wen,
  input  logic                        wr_ok,
  output logic [TABLES-1:0]           t_wen,
  output logic [TABLES-1:0][AW-1:0]   t_wadr,
  output logic [TABLES-1:0]           t_wdat
);
  logic go;
  assign go = wen && wr_ok;

  always_comb begin
    t_wen  = '0;
    t_wadr = '0;
    t_wdat = '0;
    unique case (arr)
      ARR_SPLIT: begin
        t_wen     = {go, go};
        t_wadr[0] = adr_a;
        t_wadr[1] = adr_b;
        t_wdat    = {wd_b, wd_a};
      end
      ARR_WIDE: begin
        t_wen     = {go && wd_b, go && !wd_b};
        t_wadr[0] = adr_a;
        t_wadr[1] = adr_a;
        t_wdat    = {wd_a, wd_a};
      end
      ARR_DPORT: begin
        t_wen     = {go, go};
        t_wadr[0] = adr_a;
        t_wadr[1] = adr_a;
        t_wdat    = {wd_a, wd_a};
      end
      default: begin
        t_wen = '0;
      end
    endcase
  end

  AST_NO_WRITE_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |-> t_wen == '0); // R8

  AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    arr == ARR_RSVD |-> t_wen == '0); // R7

  AST_WIDE_ONE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    arr == ARR_WIDE |-> $onehot0(t_wen)); // R2
endmodule

// File: rtl/cellram_lut.sv
module cellram_lut #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic [AW-1:0] wadr,
  input  logic          wdat,
  input  logic [AW-1:0] radr,
  output logic          rdat
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] mem_q;
  logic [DEPTH-1:0] mem_d;

  always_comb begin
    mem_d       = mem_q;
    mem_d[wadr] = wdat;
  end

  always_ff @(posedge clk) begin
    if (wen) mem_q <= mem_d;
  end

  assign rdat = mem_q[radr];

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |=> $stable(mem_q)); // R5

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wen |=> mem_q[$past(wadr)] == $past(wdat)); // R5
endmodule

// File: rtl/cellram_rd_sel.sv
module cellram_rd_sel
  import cellram_pkg::*;
#(
  parameter int AW = 4
) (
  input  arrange_e                    arr,
  input  logic [AW-1:0]               adr_a,
  input  logic [AW-1:0]               adr_b,
  input  logic                        hi_sel,
  input  logic [TABLES-1:0]           t_rdat,
  output logic [TABLES-1:0][AW-1:0]   t_radr,
  output logic                        rd_a,
  output logic                        rd_b,
  output logic                        rd_wide
);
  always_comb begin
    t_radr[0] = adr_a;
    t_radr[1] = (arr == ARR_WIDE) ? adr_a : adr_b;
  end

  always_comb begin
    rd_a    = t_rdat[0];
    rd_b    = t_rdat[1];
    rd_wide = (arr == ARR_WIDE && hi_sel) ? t_rdat[1] : t_rdat[0];
  end
endmodule

// File: rtl/cellram_top.sv
module cellram_top
  import cellram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    arrange,
  input  logic [AW-1:0] adr_a,
  input  logic [AW-1:0] adr_b,
  input  logic          wd_a,
  input  logic          wd_b,
  input  logic          wen,
  output logic          rd_a,
  output logic          rd_b,
  output logic          rd_wide
);
  arrange_e                  arr;
  logic                      wr_ok;
  logic [TABLES-1:0]         t_wen;
  logic [TABLES-1:0][AW-1:0] t_wadr;
  logic [TABLES-1:0]         t_wdat;
  logic [TABLES-1:0][AW-1:0] t_radr;
  logic [TABLES-1:0]         t_rdat;

  assign arr = arrange_e'(arrange);

  cellram_rst_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (wr_ok)
  );

  cellram_wr_dec #(.AW(AW)) u_wdec (
    .rst_n  (rst_n),
    .clk    (clk),
    .arr    (arr),
    .adr_a  (adr_a),
    .adr_b  (adr_b),
    .wd_a   (wd_a),
    .wd_b   (wd_b),
    .wen    (wen),
    .wr_ok  (wr_ok),
    .t_wen  (t_wen),
    .t_wadr (t_wadr),
    .t_wdat (t_wdat)
  );

  for (genvar t = 0; t < TABLES; t++) begin : g_tab
    cellram_lut #(.AW(AW)) u_lut (
      .clk   (clk),
      .rst_n (rst_n),
      .wen   (t_wen[t]),
      .wadr  (t_wadr[t]),
      .wdat  (t_wdat[t]),
      .radr  (t_radr[t]),
      .rdat  (t_rdat[t])
    );
  end

  cellram_rd_sel #(.AW(AW)) u_rsel (
    .arr     (arr),
    .adr_a   (adr_a),
    .adr_b   (adr_b),
    .hi_sel  (wd_b),
    .t_rdat  (t_rdat),
    .t_radr  (t_radr),
    .rd_a    (rd_a),
    .rd_b    (rd_b),
    .rd_wide (rd_wide)
  );

  AST_DPORT_MIRRORS: assert property (@(posedge clk) disable iff (!rst_n)
    (arr == ARR_DPORT && wen && wr_ok) |-> (t_wen == 2'b11 && t_wadr[0] == adr_a
      && t_wadr[1] == adr_a && t_wdat == {wd_a, wd_a})); // R4

  AST_WIDE_PICKS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (arr == ARR_WIDE && wen && wr_ok) |-> t_wen == (wd_b ? 2'b10 : 2'b01)); // R2

  AST_SPLIT_BOTH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (arr == ARR_SPLIT && wen && wr_ok) |-> (t_wen == 2'b11 && t_wadr[1] == adr_b)); // R1
endmodule

// File: tb/test_cellram_top.sv
module test_cellram_top;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    arrange;
  logic [AW-1:0] adr_a, adr_b;
  logic          wd_a, wd_b, wen;
  logic          rd_a, rd_b, rd_wide;

  always #2 clk = ~clk;

  cellram_top #(.AW(AW)) i_cellram_top (
    .clk(clk), .rst_n(rst_n), .arrange(arrange), .adr_a(adr_a), .adr_b(adr_b),
    .wd_a(wd_a), .wd_b(wd_b), .wen(wen), .rd_a(rd_a), .rd_b(rd_b), .rd_wide(rd_wide)
  );

  logic ma [DEPTH];
  logic mb [DEPTH];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;
  logic [7:0] lf = 8'h5a;

  task automatic rnd(output logic b);
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    b  = lf[0];
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Drive after a falling edge, commit at the rising edge, return on the next falling edge.
  task automatic step(input logic [1:0] m, input logic [AW-1:0] aa, input logic [AW-1:0] ab,
                      input logic b0, input logic b1, input logic w, input bit upd);
    arrange = m; adr_a = aa; adr_b = ab; wd_a = b0; wd_b = b1; wen = w;
    @(posedge clk);
    if (w && upd) begin
      case (m)
        2'b00: begin ma[aa] = b0; mb[ab] = b1; end
        2'b01: if (b1) mb[aa] = b0; else ma[aa] = b0;
        2'b10: begin ma[aa] = b0; mb[aa] = b0; end
        default: ;
      endcase
    end
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic look(input logic [1:0] m, input logic [AW-1:0] aa, input logic [AW-1:0] ab,
                      input logic b1, input string tag);
    logic ea, eb, ew;
    arrange = m; adr_a = aa; adr_b = ab; wd_b = b1; wen = 1'b0;
    #1;
    ea = ma[aa];
    if (m == 2'b01) begin
      eb = mb[aa];
      ew = b1 ? mb[aa] : ma[aa];
    end else begin
      eb = mb[ab];
      ew = ma[aa];
    end
    chk({tag, " rd_a"}, rd_a, ea);
    chk({tag, " rd_b"}, rd_b, eb);
    chk({tag, " rd_wide"}, rd_wide, ew);
    @(negedge clk);
  endtask

  task automatic t_split();
    logic x, y;
    for (int i = 0; i < DEPTH; i++) begin
      rnd(x); rnd(y);
      step(2'b00, AW'(i), AW'(i) ^ AW'(10), x, y, 1'b1, 1'b1);
    end
    for (int i = 0; i < DEPTH; i++) look(2'b00, AW'(i), AW'(DEPTH-1-i), 1'b0, "R1 R9 split");
    step(2'b00, AW'(3), AW'(3), 1'b1, 1'b0, 1'b1, 1'b1);
    look(2'b00, AW'(3), AW'(3), 1'b0, "R1 same address");
    step(2'b00, AW'(3), AW'(3), 1'b0, 1'b1, 1'b1, 1'b1);
    look(2'b00, AW'(3), AW'(3), 1'b0, "R1 same address swap");
  endtask

  task automatic t_wide();
    logic x;
    for (int i = 0; i < 2*DEPTH; i++) begin
      rnd(x);
      step(2'b01, AW'(i), AW'(0), x, i[AW], 1'b1, 1'b1);
    end
    for (int i = 0; i < 2*DEPTH; i++) look(2'b01, AW'(i), AW'(7), i[AW], "R2 R3 wide");
  endtask

  task automatic t_dport();
    logic x;
    for (int i = 0; i < DEPTH; i++) begin
      rnd(x);
      step(2'b10, AW'(i), ~AW'(i), x, ~x, 1'b1, 1'b1);
    end
    for (int i = 0; i < DEPTH; i++) look(2'b10, AW'(i), AW'(i + 5), ~ma[i], "R4 R9 dual-port");
  endtask

  task automatic t_we_low();
    for (int i = 0; i < DEPTH; i++) begin
      step(2'(i), AW'(i), AW'(i), ~ma[i], ~mb[i], 1'b0, 1'b0);
    end
    for (int i = 0; i < DEPTH; i++) look(2'b00, AW'(i), AW'(i), 1'b0, "R5 enable low");
  endtask

  task automatic t_rdw();
    logic nv;
    nv = ~ma[9];
    arrange = 2'b10; adr_a = AW'(9); adr_b = AW'(9); wd_a = nv; wd_b = 1'b0; wen = 1'b1;
    #1;
    chk("R6 port A before edge", rd_a, ~nv);
    chk("R6 port B before edge", rd_b, ~nv);
    @(posedge clk);
    ma[9] = nv; mb[9] = nv;
    #1;
    chk("R6 port A after edge", rd_a, nv);
    chk("R6 port B after edge", rd_b, nv);
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic t_rsvd();
    for (int i = 0; i < DEPTH; i += 3) begin
      step(2'b11, AW'(i), AW'(i), ~ma[i], ~mb[i], 1'b1, 1'b0);
    end
    for (int i = 0; i < DEPTH; i += 3) begin
      look(2'b11, AW'(i), AW'(i), 1'b1, "R7 reserved read");
      look(2'b00, AW'(i), AW'(i), 1'b0, "R7 reserved no write");
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(2'b00, AW'(2), AW'(2), ~ma[2], ~mb[2], 1'b1, 1'b0);
    step(2'b10, AW'(2), AW'(2), ~ma[2], 1'b0, 1'b1, 1'b0);
    rst_n = 1'b1;
    step(2'b00, AW'(2), AW'(2), ~ma[2], ~mb[2], 1'b1, 1'b0);
    step(2'b00, AW'(2), AW'(2), ~ma[2], ~mb[2], 1'b1, 1'b0);
    step(2'b00, AW'(6), AW'(6), ~ma[6], ~mb[6], 1'b1, 1'b1);
    look(2'b00, AW'(2), AW'(2), 1'b0, "R8 blocked window");
    look(2'b00, AW'(6), AW'(6), 1'b0, "R8 third edge writes");
  endtask

  initial begin
    rst_n = 1'b0; arrange = 2'b00; adr_a = '0; adr_b = '0;
    wd_a = 1'b0; wd_b = 1'b0; wen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_split();
    t_wide();
    t_dport();
    t_we_low();
    t_rdw();
    t_rsvd();
    t_split();
    t_reset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R1..: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule